// File: doc/BRIEF.md
# Multi-Cycle Register-File Processor Core

This block is a small general-purpose processor core. A control state machine steers a datapath that holds a program counter, an instruction register, a register file and one ALU. A single memory port holds both program and data. The port has one address bus, a read strobe and a write strobe. Read data is expected back in the same cycle. A write commits on the clock edge that closes the cycle in which the write strobe is high.

Every instruction takes three cycles. The fetch cycle reads the word at the program counter into the instruction register and advances the counter. The decode cycle selects an execute state from the opcode. The execute cycle does the work, and control then returns to fetch.

The instruction set has seven instructions:
- load a register from a direct address;
- store a register to a direct address;
- store through a register pointer;
- load an immediate value;
- add;
- subtract;
- an absolute jump taken when a register is zero.

The 8-bit field of an instruction is zero-extended before use. Two debug outputs give the current state code and a free-running cycle count.

Top module: `tinycpu_core`

## Requirements
- R1: While reset is held, dbgState is 0 (reset state), dbgCycles is 0 and neither memory strobe is high. The first fetch after reset reads address 0.
- R2: State codes are: 1 fetch, 2 decode, 3 direct load, 4 direct store, 5 pointer store, 6 immediate load, 7 add, 8 subtract, 9 jump-if-zero, 10 no-op. The reset state (0) is followed by fetch. Fetch is followed by decode, decode by exactly one execute state, and that execute state by fetch. In fetch, memAddr equals the program counter, memRd is high, and the counter then increments by one.
- R3: Instruction fields are: opcode in bits 15:12, first register rn in bits 11:8, second register rm in bits 7:4, 8-bit field in bits 7:0. Opcode 0000 loads rn from memory at the zero-extended field, with memRd high and memAddr equal to that address.
- R4: Opcode 0001 writes rn to memory at the zero-extended field, with memWr high for one cycle.
- R5: Opcode 0010 writes rm to memory at the address held in rn.
- R6: Opcode 0011 loads rn with the field zero-extended to 16 bits.
- R7: Opcode 0100 sets rn to rn+rm modulo 2^16.
- R8: Opcode 0101 sets rn to rn-rm modulo 2^16.
- R9: Opcode 0110 sets the program counter to the zero-extended field when rn is zero. Otherwise the incremented counter is kept.
- R10: Opcodes 0111 through 1111 run as a no-op. They raise no strobe and change no register, and are followed by fetch.
- R11: dbgCycles increments by one on every clock after reset.
- R12: memRd and memWr are never high together. memWr is high only in the cycle after decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | ADDR_W | Memory address |
| memRdData | input | DATA_W | Memory read data, same cycle |
| memWrData | output | DATA_W | Memory write data |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| dbgState | output | 4 | Current controller state code |
| dbgCycles | output | CYC_W | Cycle count since reset |

## Verification
The bench builds the core with its default parameters: 16-bit data and address, sixteen registers and a 32-bit cycle counter. The memory model has 256 words, indexed by the low eight address bits, which covers every address the test program produces. These values let the program use the full 4-bit register index. They also let it reach the 16-bit wrap of the subtract and add results, through 0 - 1 and 0xFFFF + 1. On every cycle the bench compares the state code, both strobes, the address and the write data against its reference model, and it checks a loop sum, pointer stores and a skipped block at the end.

// File: rtl/tinycpu_pkg.sv
package tinycpu_pkg;

  typedef enum logic [3:0] {
    S_RESET  = 4'd0,
    S_FETCH  = 4'd1,
    S_DECODE = 4'd2,
    S_LDDIR  = 4'd3,
    S_STDIR  = 4'd4,
    S_STIND  = 4'd5,
    S_LDIMM  = 4'd6,
    S_ADD    = 4'd7,
    S_SUB    = 4'd8,
    S_JZ     = 4'd9,
    S_NOP    = 4'd10
  } state_e;

  typedef enum logic [1:0] {
    ADDR_PC  = 2'd0,
    ADDR_DIR = 2'd1,
    ADDR_REG = 2'd2
  } addrSel_e;

  typedef enum logic [1:0] {
    WR_ALU = 2'd0,
    WR_IMM = 2'd1,
    WR_MEM = 2'd2
  } wrSel_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_PASS = 2'b10
  } aluOp_e;

  localparam logic [3:0] OP_LDDIR = 4'h0;
  localparam logic [3:0] OP_STDIR = 4'h1;
  localparam logic [3:0] OP_STIND = 4'h2;
  localparam logic [3:0] OP_LDIMM = 4'h3;
  localparam logic [3:0] OP_ADD   = 4'h4;
  localparam logic [3:0] OP_SUB   = 4'h5;
  localparam logic [3:0] OP_JZ    = 4'h6;

  typedef struct packed {
    logic     irLd;
    logic     pcInc;
    logic     pcLd;
    logic     pcClr;
    addrSel_e addrSel;
    logic     rfWr;
    wrSel_e   wrSel;
    aluOp_e   aluOp;
    logic     stFromRm;
    logic     memRd;
    logic     memWr;
  } ctrl_t;

endpackage

// File: rtl/tinycpu_alu.sv
module tinycpu_alu
  import tinycpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluOp_e            aluOp,
  output logic [DATA_W-1:0] result,
  output logic              zero
);

  always_comb begin
    case (aluOp)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      default: result = opA;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/tinycpu_datapath.sv
module tinycpu_datapath
  import tinycpu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int REG_CNT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  output logic [3:0]        opcode,
  output logic              zero,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);

  localparam int OPC_W   = 4;
  localparam int FIELD_W = 8;
  localparam int IDX_W   = $clog2(REG_CNT);
  localparam int RN_MSB  = DATA_W - OPC_W - 1;
  localparam int RM_MSB  = RN_MSB - IDX_W;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] rf [REG_CNT];
  logic [IDX_W-1:0]  rn;
  logic [IDX_W-1:0]  rm;
  logic [FIELD_W-1:0] field;
  logic [DATA_W-1:0] rd1;
  logic [DATA_W-1:0] rd2;
  logic [DATA_W-1:0] aluOut;
  logic [DATA_W-1:0] wrData;

  assign opcode = ir[DATA_W-1 -: OPC_W];
  assign rn     = ir[RN_MSB -: IDX_W];
  assign rm     = ir[RM_MSB -: IDX_W];
  assign field  = ir[FIELD_W-1:0];
  assign rd1    = rf[rn];
  assign rd2    = rf[rm];

  tinycpu_alu #(.DATA_W(DATA_W)) alu (
    .opA   (rd1),
    .opB   (rd2),
    .aluOp (ctrl.aluOp),
    .result(aluOut),
    .zero  (zero)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pc <= '0;
    else if (ctrl.pcClr)    pc <= '0;
    else if (ctrl.pcLd)     pc <= ADDR_W'(field);
    else if (ctrl.pcInc)    pc <= pc + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ir <= '0;
    else if (ctrl.irLd)     ir <= memRdData;
  end

  always_comb begin
    case (ctrl.wrSel)
      WR_ALU:  wrData = aluOut;
      WR_IMM:  wrData = DATA_W'(field);
      default: wrData = memRdData;
    endcase
  end

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   rf[g] <= '0;
      else if (ctrl.rfWr && (rn == IDX_W'(g)))     rf[g] <= wrData;
    end
  end

  always_comb begin
    case (ctrl.addrSel)
      ADDR_DIR: memAddr = ADDR_W'(field);
      ADDR_REG: memAddr = ADDR_W'(rd1);
      default:  memAddr = pc;
    endcase
  end

  assign memWrData = ctrl.stFromRm ? rd2 : rd1;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.pcInc && !ctrl.pcLd && !ctrl.pcClr) |=> (pc == $past(pc) + 1'b1)); // R2
  AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pcLd |=> (pc == ADDR_W'($past(field)))); // R9
  AST_JZ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.aluOp == ALU_PASS && !ctrl.pcLd && !ctrl.pcInc && !ctrl.pcClr) |=> $stable(pc)); // R9
  AST_NO_RF_WRITE_ON_STORE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.memWr |-> !ctrl.rfWr); // R4

endmodule

// File: rtl/tinycpu_ctrl.sv
module tinycpu_ctrl
  import tinycpu_pkg::*;
#(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       opcode,
  input  logic             zero,
  output ctrl_t            ctrl,
  output state_e           stateQ,
  output logic [CYC_W-1:0] cycles
);

  state_e stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_RESET;
      cycles <= '0;
    end else begin
      stateQ <= stateD;
      cycles <= cycles + 1'b1;
    end
  end

  always_comb begin
    case (stateQ)
      S_RESET:  stateD = S_FETCH;
      S_FETCH:  stateD = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OP_LDDIR: stateD = S_LDDIR;
          OP_STDIR: stateD = S_STDIR;
          OP_STIND: stateD = S_STIND;
          OP_LDIMM: stateD = S_LDIMM;
          OP_ADD:   stateD = S_ADD;
          OP_SUB:   stateD = S_SUB;
          OP_JZ:    stateD = S_JZ;
          default:  stateD = S_NOP;
        endcase
      end
      default:  stateD = S_FETCH;
    endcase
  end

  always_comb begin
    ctrl = '0;
    ctrl.addrSel = ADDR_PC;
    ctrl.wrSel   = WR_ALU;
    ctrl.aluOp   = ALU_ADD;
    case (stateQ)
      S_RESET: ctrl.pcClr = 1'b1;
      S_FETCH: begin
        ctrl.memRd = 1'b1;
        ctrl.irLd  = 1'b1;
        ctrl.pcInc = 1'b1;
      end
      S_LDDIR: begin
        ctrl.addrSel = ADDR_DIR;
        ctrl.memRd   = 1'b1;
        ctrl.wrSel   = WR_MEM;
        ctrl.rfWr    = 1'b1;
      end
      S_STDIR: begin
        ctrl.addrSel = ADDR_DIR;
        ctrl.memWr   = 1'b1;
      end
      S_STIND: begin
        ctrl.addrSel  = ADDR_REG;
        ctrl.stFromRm = 1'b1;
        ctrl.memWr    = 1'b1;
      end
      S_LDIMM: begin
        ctrl.wrSel = WR_IMM;
        ctrl.rfWr  = 1'b1;
      end
      S_ADD: begin
        ctrl.aluOp = ALU_ADD;
        ctrl.rfWr  = 1'b1;
      end
      S_SUB: begin
        ctrl.aluOp = ALU_SUB;
        ctrl.rfWr  = 1'b1;
      end
      S_JZ: begin
        ctrl.aluOp = ALU_PASS;
        ctrl.pcLd  = zero;
      end
      default: ;
    endcase
  end

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_FETCH) |=> (stateQ == S_DECODE)); // R2
  AST_EXEC_TO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ >= S_LDDIR) |=> (stateQ == S_FETCH)); // R2
  AST_UNDEF_IS_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_DECODE && opcode > OP_JZ) |=> (stateQ == S_NOP)); // R10
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_NOP) |-> !(ctrl.rfWr || ctrl.memWr || ctrl.memRd)); // R10
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cycles == $past(cycles) + 1'b1)); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.memRd && ctrl.memWr)); // R12

endmodule

// File: rtl/tinycpu_core.sv
module tinycpu_core
  import tinycpu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int REG_CNT = 16,
  parameter int CYC_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRd,
  output logic              memWr,
  output logic [3:0]        dbgState,
  output logic [CYC_W-1:0]  dbgCycles
);

  ctrl_t      ctrl;
  state_e     stateQ;
  logic [3:0] opcode;
  logic       zero;

  tinycpu_ctrl #(.CYC_W(CYC_W)) control (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .zero   (zero),
    .ctrl   (ctrl),
    .stateQ (stateQ),
    .cycles (dbgCycles)
  );

  tinycpu_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .REG_CNT(REG_CNT)
  ) datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opcode   (opcode),
    .zero     (zero),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .memRdData(memRdData)
  );

  assign memRd    = ctrl.memRd;
  assign memWr    = ctrl.memWr;
  assign dbgState = stateQ;

  AST_WRITE_AFTER_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> ($past(dbgState) == 4'd2)); // R12
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (dbgState == 4'd0) |-> !(memRd || memWr)); // R1

endmodule

// File: tb/tinycpu_core_test.sv
module tinycpu_core_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr;
  logic [15:0] memRdData;
  logic [15:0] memWrData;
  logic        memRd;
  logic        memWr;
  logic [3:0]  dbgState;
  logic [31:0] dbgCycles;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] mem    [256];
  logic [15:0] refMem [256];

  logic [15:0] mRf [16];
  logic [15:0] mPc;
  logic [15:0] mIr;
  int          mSt;
  int          mCyc;

  always #4 clk = ~clk;

  tinycpu_core uut (
    .clk      (clk),
    .rstN     (rstN),
    .memAddr  (memAddr),
    .memRdData(memRdData),
    .memWrData(memWrData),
    .memRd    (memRd),
    .memWr    (memWr),
    .dbgState (dbgState),
    .dbgCycles(dbgCycles)
  );

  assign memRdData = mem[memAddr[7:0]];

  always @(posedge clk) begin
    if (memWr) mem[memAddr[7:0]] <= memWrData;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input int st);
    case (st)
      0: return "R1";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      10: return "R10";
      default: return "R2";
    endcase
  endfunction

  // Compare the DUT's outputs against the model for the current cycle.
  task automatic compareCycle();
    logic [3:0]  rn;
    logic [3:0]  rm;
    logic        expRd;
    logic        expWr;
    logic [15:0] expAddr;
    logic [15:0] expData;
    string       tag;
    rn = mIr[11:8];
    rm = mIr[7:4];
    tag = reqOf(mSt);
    expRd = (mSt == 1) || (mSt == 3);
    expWr = (mSt == 4) || (mSt == 5);
    if (mSt == 3 || mSt == 4) expAddr = {8'h00, mIr[7:0]};
    else if (mSt == 5)        expAddr = mRf[rn];
    else                      expAddr = mPc;
    expData = (mSt == 5) ? mRf[rm] : mRf[rn];
    chk(tag, "state", 32'(dbgState), 32'(mSt));
    chk(tag, "memRd", 32'(memRd), 32'(expRd));
    chk("R12", "memWr", 32'(memWr), 32'(expWr));
    if (expRd || expWr) chk(tag, "memAddr", 32'(memAddr), 32'(expAddr));
    if (expWr) chk(tag, "memWrData", 32'(memWrData), 32'(expData));
    chk("R11", "cycles", dbgCycles, 32'(mCyc));
  endtask

  // Advance the model across one clock edge.
  task automatic stepModel();
    logic [3:0] rn;
    logic [3:0] rm;
    logic [3:0] op;
    rn = mIr[11:8];
    rm = mIr[7:4];
    op = mIr[15:12];
    case (mSt)
      0: mSt = 1;
      1: begin mIr = refMem[mPc[7:0]]; mPc = mPc + 16'd1; mSt = 2; end
      2: mSt = (op <= 4'd6) ? 3 + int'(op) : 10;
      default: begin
        case (mSt)
          3: mRf[rn] = refMem[mIr[7:0]];
          4: refMem[mIr[7:0]] = mRf[rn];
          5: refMem[mRf[rn][7:0]] = mRf[rm];
          6: mRf[rn] = {8'h00, mIr[7:0]};
          7: mRf[rn] = mRf[rn] + mRf[rm];
          8: mRf[rn] = mRf[rn] - mRf[rm];
          9: if (mRf[rn] == 16'd0) mPc = {8'h00, mIr[7:0]};
          default: ;
        endcase
        mSt = 1;
      end
    endcase
    mCyc++;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0]  = 16'h3000; // R0 = 0
    mem[1]  = 16'h310A; // R1 = 10
    mem[2]  = 16'h3201; // R2 = 1
    mem[3]  = 16'h3300; // R3 = 0
    mem[4]  = 16'h6108; // if R1==0 goto 8
    mem[5]  = 16'h4010; // R0 += R1
    mem[6]  = 16'h5120; // R1 -= R2
    mem[7]  = 16'h6304; // goto 4
    mem[8]  = 16'h1080; // M[80] = R0
    mem[9]  = 16'h3490; // R4 = 0x90
    mem[10] = 16'h35AB; // R5 = 0xAB
    mem[11] = 16'h2450; // M[R4] = R5
    mem[12] = 16'h0680; // R6 = M[80]
    mem[13] = 16'h4660; // R6 += R6
    mem[14] = 16'h1681; // M[81] = R6
    mem[15] = 16'hF123; // undefined
    mem[16] = 16'h75AB; // undefined
    mem[17] = 16'h5720; // R7 = 0 - 1
    mem[18] = 16'h1782; // M[82] = R7
    mem[19] = 16'h0830; // R8 = M[30]
    mem[20] = 16'h3991; // R9 = 0x91
    mem[21] = 16'h2980; // M[R9] = R8
    mem[22] = 16'h4720; // R7 = 0xFFFF + 1 = 0
    mem[23] = 16'h671A; // if R7==0 goto 26
    mem[24] = 16'h3A11; // skipped
    mem[25] = 16'h1A83; // skipped
    mem[26] = 16'h1A84; // M[84] = R10 (still 0)
    mem[27] = 16'h631B; // park
    mem[8'h30] = 16'hBEEF;
    for (int i = 0; i < 256; i++) refMem[i] = mem[i];
    for (int i = 0; i < 16; i++) mRf[i] = 16'h0000;
    mPc = 16'h0000;
    mIr = 16'h0000;
    mSt = 0;
    mCyc = 0;

    repeat (3) @(negedge clk);
    chk("R1", "reset state", 32'(dbgState), 32'd0);
    chk("R1", "reset cycles", dbgCycles, 32'd0);
    chk("R1", "reset strobes", 32'({memRd, memWr}), 32'd0);
    rstN = 1'b1;
    stepModel();
    @(negedge clk);
    chk("R1", "first fetch address", 32'(memAddr), 32'd0);
    for (int c = 0; c < 400; c++) begin
      compareCycle();
      stepModel();
      @(negedge clk);
    end

    chk("R7", "loop sum M[80]", 32'(mem[8'h80]), 32'd55);
    chk("R3", "load+add M[81]", 32'(mem[8'h81]), 32'd110);
    chk("R8", "sub wrap M[82]", 32'(mem[8'h82]), 32'hFFFF);
    chk("R6", "imm zero-ext via pointer M[90]", 32'(mem[8'h90]), 32'h00AB);
    chk("R5", "pointer store M[91]", 32'(mem[8'h91]), 32'hBEEF);
    chk("R9", "skipped store M[83]", 32'(mem[8'h83]), 32'd0);
    chk("R9", "skipped imm M[84]", 32'(mem[8'h84]), 32'd0);
    chk("R10", "parked at jump", 32'(dbgState == 4'd1 || dbgState == 4'd2 || dbgState == 4'd9), 32'd1);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) bad++;
      chk("R4", "memory image mismatches", 32'(bad), 32'd0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule